// File: doc/BRIEF.md
# Frame Buffer Write Pointer Controller

This block produces the write address, the write strobe and the registered write data for a large frame-buffer memory. It runs on one write clock. Each clock, the pointer does one of four things. It can go back to zero. It can load a start address taken from either a static configuration value or an external address bus. It can step to the next sequential location. It can hold. A separate mark input stores the current pointer value in a register without changing the pointer, so that a read side can later align itself to that location.

All controls are active low except the write mask, the source select and the trigger-mode select. The load (set) control can be edge-triggered, which gives a single load on its falling edge, or level-triggered, which loads on every cycle it stays low. Every input is registered one stage ahead of the pointer logic. As a result, a control sampled at clock edge k shows its effect on the outputs after edge k+1. The memory is expected to write `mem_data` at `wr_addr` on any edge where `mem_we` is high.

Top module: `fbw_ptr_top`

## Requirements
- R1: While `rst_n` is low, and right after its release, `wr_addr`, `mem_we`, `mem_data` and `mark_addr` are all zero.
- R2: The inputs sampled at edge k show on the outputs after edge k+1. If `wr_en_n` was high at edge k, then after edge k+1 `mem_we` is 0, and `wr_addr` and `mem_data` keep their values.
- R3: With enable low, `clr_n` high and no set trigger, `wr_addr` becomes the previous `wr_addr` plus one and `mem_data` takes the sampled `din`.
- R4: With enable low and `clr_n` low, `wr_addr` becomes 0, whatever the set input is doing.
- R5: A set trigger with `clr_n` high loads `wr_addr` from `cfg_addr` when `src_sel` is 0 and from `ext_addr` when `src_sel` is 1.
- R6: With `set_lvl` = 0 (edge mode), a set trigger happens only on a sample where `set_n` is low and was high on the previous sample. While `set_n` stays low after that, sequential incrementing continues.
- R7: With `set_lvl` = 1 (level mode), every sample with `set_n` low is a set trigger.
- R8: If `mark_n` is low at edge k, then after edge k+1 `mark_addr` holds the `wr_addr` value from just before edge k+1. This works whether or not enable is low. Mark never changes `wr_addr`.
- R9: With `wr_mask` = 1 and enable low, `mem_we` is 0 but `wr_addr` still advances as in R3, R4 and R5. With `wr_mask` = 0 and enable low, `mem_we` is 1.
- R10: A sequential step from address 2^24-1 wraps to 0.
- R11: `clr_n`, `set_n` and `src_sel` have no effect on `wr_addr` while `wr_en_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low pointer clear |
| set_n | input | 1 | Active-low pointer load |
| src_sel | input | 1 | Load source: 0 = cfg_addr, 1 = ext_addr |
| set_lvl | input | 1 | Set trigger mode: 0 = edge, 1 = level |
| mark_n | input | 1 | Active-low capture of the pointer into mark_addr |
| wr_mask | input | 1 | 1 suppresses the memory write strobe |
| ext_addr | input | 24 | External load address |
| cfg_addr | input | 24 | Configured load address |
| din | input | 12 | Write data |
| wr_addr | output | 24 | Memory write address |
| mem_we | output | 1 | Memory write strobe |
| mem_data | output | 12 | Registered write data |
| mark_addr | output | 24 | Marked pointer value for the read side |

## Verification
The bench first runs a plain sequential stream. This separates correct incrementing and data capture from the two-stage latency. Next comes a sweep in both trigger modes that mixes enable, clear, set, mark, mask and source select in interleaved periodic patterns. In those patterns `set_n` is held low for two samples in a row. The second low sample tells edge mode apart from level mode, and the overlap with clear and with disabled cycles checks the priority order and that controls are ignored while disabled. A final run loads the all-ones address and steps past it to show the wrap to zero.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    // Decoded, active-high control set captured in the input stage.
    typedef struct packed {
        logic en;
        logic clr;
        logic set;
        logic mask;
        logic mark;
    } fbw_ctl_t;

endpackage

// File: rtl/fbw_set_trig.sv
module fbw_set_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic set_n,
    input  logic lvl_mode,
    output logic trig
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = set_n;
        trig   = !set_n && (lvl_mode || prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    // R6: in edge mode a trigger cannot repeat on the following sample
    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && trig) |=> (lvl_mode || !trig));

endmodule

// File: rtl/fbw_in_stage.sv
module fbw_in_stage
    import fbw_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          clr_n,
    input  logic          set_n,
    input  logic          src_sel,
    input  logic          set_lvl,
    input  logic          mark_n,
    input  logic          wr_mask,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] din,
    output fbw_ctl_t      ctl_o,
    output logic [AW-1:0] load_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        fbw_ctl_t      ctl;
        logic [AW-1:0] load;
        logic [DW-1:0] data;
    } stage_t;

    stage_t st_d, st_q;
    logic   trig;

    fbw_set_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_n    (set_n),
        .lvl_mode (set_lvl),
        .trig     (trig)
    );

    always_comb begin
        st_d.ctl.en   = !wr_en_n;
        st_d.ctl.clr  = !clr_n;
        st_d.ctl.set  = trig;
        st_d.ctl.mask = wr_mask;
        st_d.ctl.mark = !mark_n;
        st_d.load     = src_sel ? ext_addr : cfg_addr;
        st_d.data     = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o  = st_q.ctl;
    assign load_o = st_q.load;
    assign data_o = st_q.data;

endmodule

// File: rtl/fbw_addr_core.sv
module fbw_addr_core
    import fbw_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fbw_ctl_t      ctl_i,
    input  logic [AW-1:0] load_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] data_o,
    output logic [AW-1:0] mark_o
);

    localparam logic [AW-1:0] STEP = AW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] data;
        logic [AW-1:0] mark;
    } core_t;

    core_t cs_d, cs_q;

    always_comb begin
        cs_d    = cs_q;
        cs_d.we = 1'b0;
        if (ctl_i.en) begin
            cs_d.we   = !ctl_i.mask;
            cs_d.data = data_i;
            if (ctl_i.clr)      cs_d.addr = '0;
            else if (ctl_i.set) cs_d.addr = load_i;
            else                cs_d.addr = cs_q.addr + STEP;
        end
        if (ctl_i.mark) cs_d.mark = cs_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign addr_o = cs_q.addr;
    assign we_o   = cs_q.we;
    assign data_o = cs_q.data;
    assign mark_o = cs_q.mark;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_i.en |=> ($stable(cs_q.addr) && !cs_q.we));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.en && !ctl_i.clr && !ctl_i.set) |=> (cs_q.addr == $past(cs_q.addr) + STEP));

    assert_clr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.en && ctl_i.clr) |=> (cs_q.addr == '0));

    assert_mask_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.en && ctl_i.mask) |=> !cs_q.we);

endmodule

// File: rtl/fbw_ptr_top.sv
module fbw_ptr_top
    import fbw_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          clr_n,
    input  logic          set_n,
    input  logic          src_sel,
    input  logic          set_lvl,
    input  logic          mark_n,
    input  logic          wr_mask,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] wr_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_data,
    output logic [AW-1:0] mark_addr
);

    fbw_ctl_t      ctl;
    logic [AW-1:0] load;
    logic [DW-1:0] s1_data;

    fbw_in_stage #(.AW(AW), .DW(DW)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_n  (wr_en_n),
        .clr_n    (clr_n),
        .set_n    (set_n),
        .src_sel  (src_sel),
        .set_lvl  (set_lvl),
        .mark_n   (mark_n),
        .wr_mask  (wr_mask),
        .ext_addr (ext_addr),
        .cfg_addr (cfg_addr),
        .din      (din),
        .ctl_o    (ctl),
        .load_o   (load),
        .data_o   (s1_data)
    );

    fbw_addr_core #(.AW(AW), .DW(DW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .load_i (load),
        .data_i (s1_data),
        .addr_o (wr_addr),
        .we_o   (mem_we),
        .data_o (mem_data),
        .mark_o (mark_addr)
    );

    // Edges seen since reset release; port-level checks look two samples back.
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assert_mark_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(!mark_n, 2)) |-> (mark_addr == $past(wr_addr)));

    assert_mark_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$stable(mark_addr)) |-> $past(!mark_n, 2));

    assert_ext_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(!wr_en_n && clr_n && src_sel && set_lvl && !set_n, 2))
        |-> (wr_addr == $past(ext_addr, 2)));

    assert_mask_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(!wr_en_n && wr_mask, 2)) |-> !mem_we);

endmodule

// File: tb/tb_fbw_ptr_top.sv
module tb_fbw_ptr_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en_n, clr_n, set_n, src_sel, set_lvl, mark_n, wr_mask;
    logic [23:0] ext_addr, cfg_addr;
    logic [11:0] din;
    logic [23:0] wr_addr, mark_addr;
    logic        mem_we;
    logic [11:0] mem_data;

    always #4 clk = ~clk;

    fbw_ptr_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .clr_n(clr_n),
        .set_n(set_n), .src_sel(src_sel), .set_lvl(set_lvl), .mark_n(mark_n),
        .wr_mask(wr_mask), .ext_addr(ext_addr), .cfg_addr(cfg_addr), .din(din),
        .wr_addr(wr_addr), .mem_we(mem_we), .mem_data(mem_data), .mark_addr(mark_addr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    logic [23:0] m_a, m_m;
    logic [11:0] m_d;
    logic        m_prev;
    // two-deep expectation pipe
    logic [23:0] e1_a, e1_m, e2_a, e2_m;
    logic        e1_w, e2_w;
    logic [11:0] e1_d, e2_d;
    string       e1_ta, e1_tw, e2_ta, e2_tw;
    string       tag_ovr = "";

    task automatic chk(input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a negedge: compare, advance model, drive new stimulus, go to next negedge.
    task automatic step(input logic en_n, input logic c_n, input logic s_n,
                        input logic src, input logic lvl, input logic mk_n,
                        input logic msk, input logic [23:0] ext,
                        input logic [23:0] cfg, input logic [11:0] d);
        logic trig;
        chk(e2_ta, "wr_addr", wr_addr, e2_a);
        chk(e2_tw, "mem_we", {23'd0, mem_we}, {23'd0, e2_w});
        chk("R3", "mem_data", {12'd0, mem_data}, {12'd0, e2_d});
        chk("R8", "mark_addr", mark_addr, e2_m);
        e2_a = e1_a; e2_w = e1_w; e2_d = e1_d; e2_m = e1_m;
        e2_ta = e1_ta; e2_tw = e1_tw;

        trig   = !s_n && (lvl || m_prev);
        m_prev = s_n;
        if (!mk_n) m_m = m_a;
        if (!en_n) begin
            if (!c_n)      begin m_a = 24'd0;            e1_ta = "R4"; end
            else if (trig) begin m_a = src ? ext : cfg;  e1_ta = lvl ? (src ? "R5" : "R7") : "R6"; end
            else           begin m_a = m_a + 24'd1;      e1_ta = "R3"; end
            m_d   = d;
            e1_w  = !msk;
            e1_tw = msk ? "R9" : "R3";
        end else begin
            e1_w  = 1'b0;
            e1_ta = (!c_n || trig) ? "R11" : "R2";
            e1_tw = "R2";
        end
        if (tag_ovr != "") e1_ta = tag_ovr;
        e1_a = m_a; e1_d = m_d; e1_m = m_m;

        wr_en_n = en_n; clr_n = c_n; set_n = s_n; src_sel = src; set_lvl = lvl;
        mark_n = mk_n; wr_mask = msk; ext_addr = ext; cfg_addr = cfg; din = d;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; wr_en_n = 1'b1; clr_n = 1'b1; set_n = 1'b1; src_sel = 1'b0;
        set_lvl = 1'b0; mark_n = 1'b1; wr_mask = 1'b0; ext_addr = '0; cfg_addr = '0; din = '0;
        m_a = '0; m_m = '0; m_d = '0; m_prev = 1'b1;
        e1_a = '0; e1_m = '0; e1_w = 0; e1_d = '0; e1_ta = "R1"; e1_tw = "R1";
        e2_a = '0; e2_m = '0; e2_w = 0; e2_d = '0; e2_ta = "R1"; e2_tw = "R1";
        repeat (3) @(negedge clk);
        // R1: reset values during reset
        chk("R1", "wr_addr", wr_addr, 24'd0);
        chk("R1", "mem_we", {23'd0, mem_we}, 24'd0);
        chk("R1", "mark_addr", mark_addr, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_data", {12'd0, mem_data}, 24'd0);

        // Plain sequential stream (R3)
        for (int i = 0; i < 24; i++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'd0, 24'd0, 12'(i * 37 + 5));

        // Mixed sweep in both trigger modes (R2, R4..R9, R11)
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int i = 0; i < 160; i++) begin
                step((i % 5) == 4,
                     !((i % 7) == 3),
                     ((i >> 1) & 3) != 0,
                     ((i >> 4) & 1) == 1,
                     lvl[0],
                     !((i % 6) == 2),
                     (i % 4) == 1,
                     24'(i * 24'h010203 + 24'h400000),
                     24'(24'h00A000 + lvl * 24'h100),
                     12'(i * 53 + lvl));
            end
        end

        // Wrap: load all-ones from cfg, then step past it (R10)
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'd0, 24'hFFFFFF, 12'h111);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'd0, 24'hFFFFFF, 12'h222);
        tag_ovr = "R10";
        for (int i = 0; i < 4; i++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'd0, 24'hFFFFFF, 12'(i + 3));
        tag_ovr = "";
        // flush pipe
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'd0, 24'd0, 12'd0);
        done = 1;
        summary();
    end

endmodule